// File: doc/BRIEF.md
# Errored Second Threshold Monitor

The block classifies each one-second interval of a line as errored, bursty errored and/or severely errored. A strobe input reports single error events and a tick input marks the end of each second. At every tick the monitor takes the number of events counted in the second that just closed. It issues a one-cycle pulse for each class that applies, adds one to a saturating occurrence counter for that class, and begins counting the next second.

A small write port holds a 2-bit mode selector, an 8-bit errored-second limit and a 16-bit severe-second limit. The 16-bit limit is written as a high byte and a low byte. In default mode the classes follow fixed rules, and the severe boundary is a parameter. In threshold mode a second is errored or severe when its event count is strictly above the programmed limit. A limit of zero switches that check off, and the bursty class never fires. Writes to the registers do not act at once: they are applied at the next second boundary, so the second in progress is always judged by a single, consistent set of rules.

Top module: `errsec_mon`

## Requirements
- R1: After reset all flags and all three occurrence counts read 0, and all registers read 0, so the block runs in default mode.
- R2: Default mode: a second with at least one error event gives an errored-second pulse on `es_o`.
- R3: Default mode: a second with at least 2 events and fewer than `SES_DEF` (320) events gives a bursty pulse on `bes_o`. A second with 0, 1, or `SES_DEF` or more events does not.
- R4: Default mode: a second with `SES_DEF` or more events gives a severe pulse on `ses_o`.
- R5: Threshold mode (register 0 field [1:0] = 2'b01): `es_o` pulses when the events are strictly greater than the register 1 limit. A limit of 0 disables `es_o`.
- R6: Threshold mode: `ses_o` pulses when the events are strictly greater than the 16-bit limit, whose bits 15..8 are in register 2 and bits 7..0 in register 3. A limit of 0 disables `ses_o`.
- R7: Threshold mode: `bes_o` never pulses.
- R8: Mode values 2'b10 and 2'b11 behave exactly as default mode.
- R9: An error strobe in the same cycle as the tick is counted in the new second, not in the one being closed.
- R10: Register writes take effect at the next tick. The second that closes at that tick is still classified with the previous settings.
- R11: Flags are high for exactly the one cycle after the tick cycle, and never at any other time.
- R12: Each flag pulse adds one to its 16-bit count (`es_cnt_o`, `bes_cnt_o`, `ses_cnt_o`). The count changes in the same cycle the pulse appears and holds at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | One error event per high cycle |
| tick_i | input | 1 | One-second boundary marker, one cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 mode, 1 ES limit, 2 SES limit high, 3 SES limit low |
| wr_data_i | input | 8 | Register write data |
| es_o | output | 1 | Errored second pulse |
| bes_o | output | 1 | Bursty errored second pulse |
| ses_o | output | 1 | Severely errored second pulse |
| es_cnt_o | output | 16 | Errored second count |
| bes_cnt_o | output | 16 | Bursty errored second count |
| ses_cnt_o | output | 16 | Severely errored second count |

## Verification
The hardest state to reach is a saturated occurrence counter, because it takes 65535 classified seconds. The bench holds both the tick and the error strobe high on every cycle, so each one-cycle "second" carries exactly one event and is errored. About 65.5k cycles then drive the errored count to its ceiling, after which the count must stay at 0xFFFF. Register writes are checked at the boundary by writing in the middle of a second and confirming that the old rules still classify that second.

// File: rtl/errsec_pkg.sv
package errsec_pkg;
  typedef enum logic [1:0] {
    MODE_DEF  = 2'b00,
    MODE_THR  = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_MODE    = 2'd0;
  localparam logic [1:0] ADDR_EST     = 2'd1;
  localparam logic [1:0] ADDR_SEST_HI = 2'd2;
  localparam logic [1:0] ADDR_SEST_LO = 2'd3;

  localparam int NUM_CLS = 3;
  localparam int CLS_ES  = 0;
  localparam int CLS_BES = 1;
  localparam int CLS_SES = 2;
endpackage

// File: rtl/errsec_regs.sv
module errsec_regs
  import errsec_pkg::*;
#(
  parameter int EST_W  = 8,
  parameter int SEST_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output mode_e             mode_o,
  output logic [EST_W-1:0]  est_o,
  output logic [SEST_W-1:0] sest_o
);
  localparam int HI_W = SEST_W - 8;

  logic [1:0]        mode_q;
  logic [EST_W-1:0]  est_q;
  logic [SEST_W-1:0] sest_q;

  // staged copies, written any time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      est_q  <= '0;
      sest_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_MODE:    mode_q <= wr_data_i[1:0];
        ADDR_EST:     est_q <= EST_W'(wr_data_i);
        ADDR_SEST_HI: sest_q[SEST_W-1:8] <= wr_data_i[HI_W-1:0];
        ADDR_SEST_LO: sest_q[7:0] <= wr_data_i;
        default: ;
      endcase
    end
  end

  // active copies, applied at the second boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_DEF;
      est_o  <= '0;
      sest_o <= '0;
    end else if (tick_i) begin
      mode_o <= mode_e'(mode_q);
      est_o  <= est_q;
      sest_o <= sest_q;
    end
  end
endmodule

// File: rtl/errsec_evcnt.sv
module errsec_evcnt #(
  parameter int EV_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            err_i,
  input  logic            tick_i,
  output logic [EV_W-1:0] ev_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ev_cnt_o <= '0;
    else if (tick_i)
      ev_cnt_o <= EV_W'(err_i);  // tick-cycle event opens the new second
    else if (err_i && ev_cnt_o != '1)
      ev_cnt_o <= ev_cnt_o + 1'b1;
  end
endmodule

// File: rtl/errsec_classify.sv
module errsec_classify
  import errsec_pkg::*;
#(
  parameter int EV_W    = 16,
  parameter int EST_W   = 8,
  parameter int SEST_W  = 16,
  parameter int SES_DEF = 320
) (
  input  mode_e              mode_i,
  input  logic [EST_W-1:0]   est_i,
  input  logic [SEST_W-1:0]  sest_i,
  input  logic [EV_W-1:0]    ev_cnt_i,
  output logic [NUM_CLS-1:0] cls_o
);
  localparam logic [EV_W-1:0] SES_LIM = EV_W'(SES_DEF);

  always_comb begin
    cls_o = '0;
    if (mode_i == MODE_THR) begin
      cls_o[CLS_ES]  = (est_i != '0) && (ev_cnt_i > EV_W'(est_i));
      cls_o[CLS_SES] = (sest_i != '0) && (ev_cnt_i > EV_W'(sest_i));
    end else begin
      cls_o[CLS_ES]  = ev_cnt_i != '0;
      cls_o[CLS_BES] = (ev_cnt_i >= EV_W'(2)) && (ev_cnt_i < SES_LIM);
      cls_o[CLS_SES] = ev_cnt_i >= SES_LIM;
    end
  end
endmodule

// File: rtl/errsec_satcnt.sv
module errsec_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_o <= '0;
    else if (inc_i && cnt_o != '1)
      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/errsec_mon.sv
module errsec_mon
  import errsec_pkg::*;
#(
  parameter int EV_W    = 16,
  parameter int EST_W   = 8,
  parameter int SEST_W  = 16,
  parameter int CNT_W   = 16,
  parameter int SES_DEF = 320
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  output logic             es_o,
  output logic             bes_o,
  output logic             ses_o,
  output logic [CNT_W-1:0] es_cnt_o,
  output logic [CNT_W-1:0] bes_cnt_o,
  output logic [CNT_W-1:0] ses_cnt_o
);
  mode_e              mode_act;
  logic [EST_W-1:0]   est_act;
  logic [SEST_W-1:0]  sest_act;
  logic [EV_W-1:0]    ev_cnt;
  logic [NUM_CLS-1:0] cls, flag_q;
  logic [CNT_W-1:0]   occ_cnt [NUM_CLS];

  errsec_regs #(.EST_W(EST_W), .SEST_W(SEST_W)) u_regs (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode_act), .est_o(est_act), .sest_o(sest_act)
  );

  errsec_evcnt #(.EV_W(EV_W)) u_evcnt (
    .clk_i, .rst_ni, .err_i, .tick_i, .ev_cnt_o(ev_cnt)
  );

  errsec_classify #(
    .EV_W(EV_W), .EST_W(EST_W), .SEST_W(SEST_W), .SES_DEF(SES_DEF)
  ) u_cls (
    .mode_i(mode_act), .est_i(est_act), .sest_i(sest_act),
    .ev_cnt_i(ev_cnt), .cls_o(cls)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= tick_i ? cls : '0;
  end

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_occ
    errsec_satcnt #(.CNT_W(CNT_W)) u_occ (
      .clk_i, .rst_ni, .inc_i(tick_i & cls[g]), .cnt_o(occ_cnt[g])
    );
  end

  assign es_o      = flag_q[CLS_ES];
  assign bes_o     = flag_q[CLS_BES];
  assign ses_o     = flag_q[CLS_SES];
  assign es_cnt_o  = occ_cnt[CLS_ES];
  assign bes_cnt_o = occ_cnt[CLS_BES];
  assign ses_cnt_o = occ_cnt[CLS_SES];
endmodule

// File: rtl/errsec_mon_chk.sv
module errsec_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       mode_act,
  input logic             es_o,
  input logic             bes_o,
  input logic             ses_o,
  input logic [CNT_W-1:0] es_cnt_o,
  input logic [CNT_W-1:0] bes_cnt_o,
  input logic [CNT_W-1:0] ses_cnt_o
);
  p_flag_after_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (es_o || bes_o || ses_o) |-> $past(tick_i));

  p_es_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (es_o && !tick_i) |=> !es_o);

  p_no_bes_thr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_i && mode_act == 2'b01) |-> !bes_o);

  p_bes_has_es_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bes_o |-> es_o);

  p_es_cnt_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (es_o && $past(es_cnt_o) != '1) |-> es_cnt_o == $past(es_cnt_o) + 1'b1);

  p_es_cnt_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !es_o |-> $stable(es_cnt_o));

  p_bes_cnt_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bes_o |-> $stable(bes_cnt_o));

  p_ses_cnt_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ses_o |-> $stable(ses_cnt_o));
endmodule

bind errsec_mon errsec_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_act(mode_act),
  .es_o(es_o), .bes_o(bes_o), .ses_o(ses_o),
  .es_cnt_o(es_cnt_o), .bes_cnt_o(bes_cnt_o), .ses_cnt_o(ses_cnt_o)
);

// File: tb/sim_errsec_mon.sv
`timescale 1ns/1ps
module sim_errsec_mon;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        err_i = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        es_o, bes_o, ses_o;
  logic [15:0] es_cnt_o, bes_cnt_o, ses_cnt_o;

  int n_chk = 0, n_fail = 0;
  int exp_es = 0, exp_bes = 0, exp_ses = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  errsec_mon u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i) rst_ni = 1'b0;
    err_i = 0; tick_i = 0; wr_en_i = 0;
    @(negedge clk_i) rst_ni = 1'b1;
    exp_es = 0; exp_bes = 0; exp_ses = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i) begin wr_en_i = 1; wr_addr_i = a; wr_data_i = d; end
    @(negedge clk_i) wr_en_i = 0;
  endtask

  // n error cycles, then the tick; checks pulses and counts
  task automatic second(input string req, input int n, input bit tick_err,
                        input bit e, input bit b, input bit s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) err_i = 1;
    end
    @(negedge clk_i) begin err_i = tick_err; tick_i = 1; end
    @(negedge clk_i) begin err_i = 0; tick_i = 0; end
    check({req, " es"}, es_o, e);
    check({req, " bes"}, bes_o, b);
    check({req, " ses"}, ses_o, s);
    exp_es += e; exp_bes += b; exp_ses += s;
    check({req, " es_cnt R12"}, es_cnt_o, exp_es);
    check({req, " bes_cnt R12"}, bes_cnt_o, exp_bes);
    check({req, " ses_cnt R12"}, ses_cnt_o, exp_ses);
    @(negedge clk_i);
    check({req, " pulse width R11"}, {es_o, bes_o, ses_o}, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 es", es_o, 0); check("R1 bes", bes_o, 0); check("R1 ses", ses_o, 0);
    check("R1 cnt", es_cnt_o | bes_cnt_o | ses_cnt_o, 0);
    second("R1 default after reset", 1, 0, 1, 0, 0);
  endtask

  task automatic t_default();
    second("R2 zero events", 0, 0, 0, 0, 0);
    second("R2 one event", 1, 0, 1, 0, 0);
    second("R3 two events", 2, 0, 1, 1, 0);
    second("R3 319 events", 319, 0, 1, 1, 0);
    second("R4 320 events", 320, 0, 1, 0, 1);
    second("R4 500 events", 500, 0, 1, 0, 1);
  endtask

  task automatic t_tick_err();
    second("R9 event on tick only", 0, 1, 0, 0, 0);
    second("R9 carried event", 0, 0, 1, 0, 0);
  endtask

  task automatic t_boundary();
    // write mid-second: this second still uses default rules
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i) err_i = 1;
    end
    @(negedge clk_i) err_i = 0;
    wr(2'd0, 8'h01); wr(2'd1, 8'd10);
    second("R10 old rules", 0, 0, 1, 1, 0);
    second("R10 new rules", 3, 0, 0, 0, 0);
  endtask

  task automatic t_threshold();
    wr(2'd1, 8'd5); wr(2'd2, 8'h01); wr(2'd3, 8'h00);
    second("R10 apply", 0, 0, 0, 0, 0);
    second("R5 at limit", 5, 0, 0, 0, 0);
    second("R5 above limit", 6, 0, 1, 0, 0);
    second("R7 bursty range", 100, 0, 1, 0, 0);
    second("R6 at limit", 256, 0, 1, 0, 0);
    second("R6 above limit", 257, 0, 1, 0, 1);
    wr(2'd1, 8'd0); wr(2'd2, 8'd0);
    second("R6 apply zero", 0, 0, 0, 0, 0);
    second("R5 R6 zero disables", 300, 0, 0, 0, 0);
  endtask

  task automatic t_reserved();
    wr(2'd0, 8'h02);
    second("R8 apply 10", 0, 0, 0, 0, 0);
    second("R8 mode 10", 2, 0, 1, 1, 0);
    wr(2'd0, 8'h03);
    second("R8 apply 11", 320, 0, 1, 0, 1);
    second("R8 mode 11", 1, 0, 1, 0, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    @(negedge clk_i) begin err_i = 1; tick_i = 1; end
    repeat (65600) @(negedge clk_i);
    err_i = 0; tick_i = 0;
    @(negedge clk_i);
    check("R12 es saturated", es_cnt_o, 16'hFFFF);
    check("R12 bes untouched", bes_cnt_o, 0);
  endtask

  initial begin
    t_reset();
    t_default();
    t_tick_err();
    t_boundary();
    t_threshold();
    t_reserved();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule